// File: doc/BRIEF.md
# NAND Ready/Busy Wait Monitor

After a command sequencer has issued a command to a NAND flash device, this block watches the device's ready/busy line and tells the sequencer when the device has finished. A one-cycle `start_i` pulse arms the monitor. The monitor then ignores the line for a blanking interval, because the device may not have pulled the line low yet. The interval length comes from a 4-bit scaling field and a relaxed-timing select. Both values are captured when the start pulse arrives.

When the blanking interval ends, the monitor samples the synchronised line on every clock. It declares the device ready only after the line reads high on two consecutive clocks. This prevents a noisy rising edge from producing a false ready. While the monitor waits, it holds `busy_o` high. When it declares ready, it issues a single-cycle `ready_o` pulse, and `busy_o` goes low in that same cycle.

The controller is a state machine with five states:
- IDLE: nothing pending.
- BLANK: the blanking counter is running.
- SAMPLE: waiting for a first high sample.
- CONFIRM: one high sample seen, waiting for a second.
- DONE: the ready pulse cycle.

The transitions are:
- Arm: any state goes to BLANK on `start_i`.
- Expire: BLANK goes to SAMPLE when the counter reaches zero.
- First-high: SAMPLE goes to CONFIRM on a high sample.
- Drop: CONFIRM goes back to SAMPLE on a low sample.
- Confirm: CONFIRM goes to DONE on a high sample.
- Retire: DONE goes to IDLE.

Top module: `nand_rb_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o` and `ready_o` are both 0.
- R2: A `start_i` pulse makes `busy_o` 1 in the next cycle, with `ready_o` 0. The ready/busy line has no effect while the blanking interval runs.
- R3: With `relaxed_i` = 0, the blanking interval lasts 8 × (2 + `scale_i`) clocks. With the line already high, `busy_o` is observed high for exactly 8 × (2 + `scale_i`) + 2 cycles, and then `ready_o` follows.
- R4: With `relaxed_i` = 1, the blanking interval lasts 16 × (2 + `scale_i`) clocks. With the line already high, the observed busy period is 16 × (2 + `scale_i`) + 2 cycles.
- R5: The line passes through two synchronising flops before sampling. Line level 1 means ready and 0 means busy. Ready is declared only after two consecutive high synchronised samples.
- R6: A single high sample followed by a low sample cancels the partial confirmation, and the monitor keeps waiting with `busy_o` = 1.
- R7: A `start_i` pulse that arrives while the monitor is waiting restarts the blanking interval from its full length.
- R8: `ready_o` is high for exactly one cycle per completed wait. `busy_o` is 0 in that cycle and stays 0 afterwards until the next start.
- R9: While the line stays low after blanking, `busy_o` stays 1 for as long as the line stays low, and no ready pulse is issued.
- R10: `relaxed_i` and `scale_i` are captured at the start pulse. Changing them during a wait does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: a command was issued, begin waiting |
| relaxed_i | input | 1 | 1 selects the long (16×) blanking base, 0 the short (8×) base |
| scale_i | input | 4 | Unsigned cycle-scaling field added to 2 in the blanking length |
| rb_pin_i | input | 1 | Raw ready/busy line from the device (1 = ready) |
| busy_o | output | 1 | High while a wait is in progress |
| ready_o | output | 1 | One-cycle pulse when the device is declared ready |

## Verification
The main function is exercised with the line held high before the start pulse, in both timing modes, at the smallest and largest scaling values and at one value in between. Each of these runs measures the exact busy length, which separates a wrong base, a wrong offset and an off-by-one in the counter. A one-cycle high glitch between low periods separates a debounce that requires two consecutive samples from one that requires only a single sample. A second start in the middle of a wait, and a change to the scaling inputs after the start, show whether the interval is restarted and whether the settings were captured at the start pulse. A behavioural model that predicts both outputs on every clock catches any other deviation in the cycle where it occurs.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BLANK   = 3'd1,
        ST_SAMPLE  = 3'd2,
        ST_CONFIRM = 3'd3,
        ST_DONE    = 3'd4
    } nrb_state_e;

endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nrb_blank_timer.sv
module nrb_blank_timer #(
    parameter int SCALE_W    = 4,
    parameter int BASE_SHORT = 8,
    parameter int BASE_LONG  = 16,
    parameter int OFFSET     = 2,
    localparam int MAX_SPAN  = BASE_LONG * (OFFSET + (1 << SCALE_W) - 1),
    localparam int CNT_W     = $clog2(MAX_SPAN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               relaxed_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               expired_o
);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;
    int               span;

    always_comb begin
        span     = (relaxed_i ? BASE_LONG : BASE_SHORT) * (OFFSET + int'(scale_i));
        load_val = CNT_W'(span - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               remain_q <= '0;
        else if (load_i)          remain_q <= load_val;
        else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
    end

    assign expired_o = (remain_q == '0);

endmodule

// File: rtl/nand_rb_monitor.sv
module nand_rb_monitor #(
    parameter int SCALE_W     = 4,
    parameter int BASE_SHORT  = 8,
    parameter int BASE_LONG   = 16,
    parameter int OFFSET      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               relaxed_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               rb_pin_i,
    output logic               busy_o,
    output logic               ready_o
);
    import nrb_pkg::*;

    nrb_state_e state_q, state_d;
    logic       rb_clean;
    logic       blank_done;

    nrb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rb_pin_i),
        .sync_o  (rb_clean)
    );

    nrb_blank_timer #(
        .SCALE_W    (SCALE_W),
        .BASE_SHORT (BASE_SHORT),
        .BASE_LONG  (BASE_LONG),
        .OFFSET     (OFFSET)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_i),
        .relaxed_i (relaxed_i),
        .scale_i   (scale_i),
        .expired_o (blank_done)
    );

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_BLANK;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_BLANK:   if (blank_done) state_d = ST_SAMPLE;
                ST_SAMPLE:  if (rb_clean)   state_d = ST_CONFIRM;
                ST_CONFIRM: state_d = rb_clean ? ST_DONE : ST_SAMPLE;
                ST_DONE:    state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_o  = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_BLANK,
            ST_SAMPLE,
            ST_CONFIRM: busy_o  = 1'b1;
            ST_DONE:    ready_o = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/nand_rb_monitor_chk.sv
module nand_rb_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic rb_clean,
    input logic busy_o,
    input logic ready_o
);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !ready_o));

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !busy_o);

    // R8
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    // R5
    ready_two_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(rb_clean, 1) && $past(rb_clean, 2)));

    // R9
    low_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rb_clean && !start_i) |=> !ready_o);

endmodule

bind nand_rb_monitor nand_rb_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rb_clean (rb_clean),
    .busy_o   (busy_o),
    .ready_o  (ready_o)
);

// File: tb/nand_rb_monitor_test.sv
module nand_rb_monitor_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       relaxed_i = 1'b0;
    logic [3:0] scale_i = 4'd0;
    logic       rb_pin_i = 1'b0;
    logic       busy_o, ready_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    nand_rb_monitor uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .relaxed_i(relaxed_i),
        .scale_i(scale_i), .rb_pin_i(rb_pin_i), .busy_o(busy_o), .ready_o(ready_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: phase 0 idle, 1 blanking, 2 waiting first high,
    // 3 waiting second high, 4 ready pulse
    bit pin_q[$];
    int phase = 0;
    int remain = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q = {1'b0, 1'b0};
            phase = 0;
            remain = 0;
        end else begin
            bit seen;
            seen = pin_q.pop_front();
            pin_q.push_back(rb_pin_i);
            if (start_i) begin
                phase = 1;
                remain = (relaxed_i ? 16 : 8) * (2 + int'(scale_i)) - 1;
            end else begin
                case (phase)
                    1: if (remain == 0) phase = 2; else remain--;
                    2: if (seen) phase = 3;
                    3: phase = seen ? 4 : 2;
                    4: phase = 0;
                    default: phase = 0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_busy, exp_ready;
            exp_busy  = (phase >= 1 && phase <= 3);
            exp_ready = (phase == 4);
            tests++;
            if (busy_o !== exp_busy) begin
                fails++;
                $display("FAIL R3 busy per-cycle: got %0b expected %0b at %0t", busy_o, exp_busy, $time);
            end
            tests++;
            if (ready_o !== exp_ready) begin
                fails++;
                $display("FAIL R8 ready per-cycle: got %0b expected %0b at %0t", ready_o, exp_ready, $time);
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic pulse_start(input bit rel, input logic [3:0] sc);
        @(negedge clk);
        relaxed_i = rel;
        scale_i   = sc;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    // Counts busy cycles observed after the start pulse until ready
    task automatic measure(input string req, input bit rel, input logic [3:0] sc, input int exp);
        int n;
        n = 0;
        @(negedge clk);
        relaxed_i = rel;
        scale_i   = sc;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        while (!ready_o && n < 2000) begin
            if (busy_o) n++;
            @(negedge clk);
        end
        check(req, n, exp);
        @(negedge clk);
        check("R8 pulse ends", int'(ready_o), 0);
        check("R8 busy stays low", int'(busy_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: got timeout expected completion");
        fails++;
        tests++;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 1);
        check("R1 busy in reset", int'(busy_o), 0);
        check("R1 ready in reset", int'(ready_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 ready after reset", int'(ready_o), 0);

        rb_pin_i = 1'b1;
        repeat (4) @(negedge clk);
        measure("R3 short scale 0", 1'b0, 4'd0, 18);
        measure("R3 short scale 5", 1'b0, 4'd5, 58);
        measure("R4 long scale 0", 1'b1, 4'd0, 34);
        measure("R4 long scale 15", 1'b1, 4'd15, 274);

        // R2: start raises busy next cycle, line ignored during blanking
        pulse_start(1'b0, 4'd2);
        check("R2 busy after start", int'(busy_o), 1);
        check("R2 no ready after start", int'(ready_o), 0);
        repeat (20) @(negedge clk);
        check("R2 still blanking with line high", int'(busy_o), 1);
        repeat (20) @(negedge clk);

        // R10: change settings after the start pulse
        @(negedge clk);
        relaxed_i = 1'b0; scale_i = 4'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; relaxed_i = 1'b1; scale_i = 4'd15;
        begin
            int n;
            n = 0;
            while (!ready_o && n < 2000) begin
                if (busy_o) n++;
                @(negedge clk);
            end
            check("R10 settings captured", n, 18);
        end
        relaxed_i = 1'b0; scale_i = 4'd0;
        repeat (3) @(negedge clk);

        // R9 / R6: line low, then single-cycle glitch
        rb_pin_i = 1'b0;
        repeat (3) @(negedge clk);
        pulse_start(1'b0, 4'd0);
        repeat (300) @(negedge clk);
        check("R9 busy while line low", int'(busy_o), 1);
        rb_pin_i = 1'b1;
        @(negedge clk);
        rb_pin_i = 1'b0;
        repeat (10) @(negedge clk);
        check("R6 glitch keeps busy", int'(busy_o), 1);
        check("R6 glitch no ready", int'(ready_o), 0);
        rb_pin_i = 1'b1;
        begin
            int n;
            n = 0;
            while (!ready_o && n < 100) begin
                n++;
                @(negedge clk);
            end
            // two sync flops, then SAMPLE and CONFIRM: ready observed after 4 edges
            check("R5 ready after two high samples", n, 4);
        end
        repeat (3) @(negedge clk);

        // R7: restart mid-wait
        pulse_start(1'b0, 4'd1);
        repeat (10) @(negedge clk);
        measure("R7 restart full length", 1'b0, 4'd1, 26);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule